// File: doc/BRIEF.md
# Fractional NCO Baud Tick Generator

This block produces the 16x oversampling enable for a UART from a fixed system clock. It is built as a phase accumulator, not as an integer divider. Every clock it adds a programmed increment to a 16-bit accumulator. Each carry out of the accumulator gives a one-cycle tick. The tick rate is therefore f_clk · inc / 2^16. To get a 16x oversampled baud rate, software loads inc = baud · 2^20 / f_clk. With a 100 MHz clock the top rate is f_clk / 16, and lower rates keep fractional precision.

The 16-bit increment is written as two bytes, one write per byte, chosen by a select bit. Either byte can be read back. The increment may only be changed while the generator is disabled, and writes made while it runs are dropped. Clearing the enable stops the ticks and resets the accumulator to zero, so the tick pattern after each enable is always the same.

Top module: `nco_baud_gen`

## Requirements
- R1: After reset the increment is zero, both read-back bytes are zero and `tick` is low.
- R2: A write with `en` low stores `wr_data` into the upper byte of the increment when `wr_sel` is 1, or into the lower byte when `wr_sel` is 0. `rd_data` returns the upper byte when `rd_sel` is 1 and the lower byte when `rd_sel` is 0.
- R3: A write made while `en` is high is ignored, and the stored increment does not change.
- R4: If `en` is held high for K clock edges starting from a disabled state, `tick` is high on exactly floor(K · inc / 65536) of those edges.
- R5: `tick` is registered and lasts one cycle per carry. After `en` rises, the first tick appears on edge number ceil(65536 / inc).
- R6: While `en` is low the accumulator stays at zero. Re-enabling repeats the same first-tick position whatever phase was reached before the disable.
- R7: An increment of zero produces no tick.
- R8: `tick` is low on the first edge at which `en` is sampled low, and on every edge after that until `en` is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Generator enable; the increment can be written only while this is low |
| wr_en | input | 1 | Write strobe for one increment byte |
| wr_sel | input | 1 | Byte select for writes: 1 = upper, 0 = lower |
| wr_data | input | 8 | Byte to write |
| rd_sel | input | 1 | Byte select for read-back: 1 = upper, 0 = lower |
| rd_data | output | 8 | Selected increment byte |
| tick | output | 1 | One-cycle oversample enable |

## Verification
The assertions assume that `en`, `wr_en` and the write fields are stable at each rising edge and free of unknown values once reset is released. They also assume a write can land in the same cycle that `en` changes, in which case the sampled `en` decides whether it is kept. The bench changes every input only on the falling edge, so each input is settled a half period before it is sampled. It always starts a counted run from a disabled state, which lets the expected tick count follow directly from the floor formula.

// File: rtl/nco_baud_gen.sv
module nco_baud_gen #(
  parameter int INC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [INC_W/2-1:0] wr_data,
  input  logic               rd_sel,
  output logic [INC_W/2-1:0] rd_data,
  output logic               tick
);
  localparam int HALF = INC_W / 2;

  logic [INC_W-1:0] inc_q;
  logic [INC_W-1:0] acc_q;
  logic             tick_q;
  logic [INC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, inc_q};
  assign rd_data = rd_sel ? inc_q[INC_W-1:HALF] : inc_q[HALF-1:0];
  assign tick    = tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_q  <= '0;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (wr_en && !en) begin
        if (wr_sel) inc_q[INC_W-1:HALF] <= wr_data;
        else        inc_q[HALF-1:0]     <= wr_data;
      end
      if (en) begin
        acc_q  <= sum[INC_W-1:0];
        tick_q <= sum[INC_W];
      end else begin
        acc_q  <= '0;
        tick_q <= 1'b0;
      end
    end
  end

  // R3
  locked_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(inc_q));

  // R2
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !en && wr_sel) |=> (inc_q[INC_W-1:HALF] == $past(wr_data)));

  // R2
  lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !en && !wr_sel) |=> (inc_q[HALF-1:0] == $past(wr_data)));

  // R6
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc_q == '0));

  // R8
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);

  // R7
  zero_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_q == '0) |=> !tick);
endmodule

// File: tb/sim_nco_baud_gen.sv
module sim_nco_baud_gen;
  logic clk = 1'b0;
  logic rst_n, en, wr_en, wr_sel, rd_sel;
  logic [7:0] wr_data, rd_data;
  logic tick;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  nco_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick)
  );

  localparam int NV = 6;
  localparam int KRUN = 1000;
  localparam logic [15:0] INC_TAB [NV] = '{16'h8000, 16'h1000, 16'h2A3B,
                                           16'hFFFF, 16'h0100, 16'h0693};

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    wr_byte(1'b1, v[15:8]);
    wr_byte(1'b0, v[7:0]);
  endtask

  task automatic rd_byte(input logic sel, output logic [7:0] d);
    rd_sel = sel; #1; d = rd_data;
  endtask

  task automatic run(input int k, output int cnt, output int first);
    cnt = 0; first = 0;
    en = 1'b1;
    for (int i = 1; i <= k; i++) begin
      @(negedge clk);
      if (tick) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int cnt, first, cnt2, first2;
    rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 tick", tick, 0);
    rd_byte(1'b1, b); check("R1 hi", b, 0);
    rd_byte(1'b0, b); check("R1 lo", b, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: zero increment, no ticks
    run(300, cnt, first);
    check("R7 zero inc", cnt, 0);

    // R2 / R4: table walk
    for (int v = 0; v < NV; v++) begin
      load(INC_TAB[v]);
      rd_byte(1'b1, b); check("R2 hi", b, INC_TAB[v][15:8]);
      rd_byte(1'b0, b); check("R2 lo", b, INC_TAB[v][7:0]);
      run(KRUN, cnt, first);
      check("R4 count", cnt, (longint'(KRUN) * INC_TAB[v]) >> 16);
    end

    // R5: first tick position
    load(16'h4000);
    run(10, cnt, first);
    check("R5 first", first, 4);
    check("R5 count", cnt, 2);

    // R6: restart after partial phase gives same first tick
    load(16'h3000);
    run(50, cnt, first);
    check("R6 first a", first, 6);
    run(7, cnt2, first2);
    check("R6 first b", first2, 6);
    check("R6 count b", cnt2, 1);

    // R3: write while running is ignored
    load(16'h1234);
    en = 1'b1;
    @(negedge clk);
    wr_byte(1'b1, 8'hAB);
    wr_byte(1'b0, 8'hCD);
    en = 1'b0;
    @(negedge clk);
    rd_byte(1'b1, b); check("R3 hi", b, 8'h12);
    rd_byte(1'b0, b); check("R3 lo", b, 8'h34);

    // R8: tick drops at first disabled edge
    load(16'hFFFF);
    en = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 running", tick, 1);
    en = 1'b0;
    @(negedge clk);
    check("R8 stop", tick, 0);
    repeat (3) @(negedge clk);
    check("R8 idle", tick, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule